// File: doc/BRIEF.md
# Boot Mode Strap Decoder and Start-Up Sequencer

This block sits beside the reset controller of a partitionable PCI Express switch. When the active-low global reset is released, it samples a 4-bit mode strap and a halt strap once, and from then on ignores both pins. From the mode code it works out four things: single-partition or multi-partition operation, whether configuration is loaded from a serial EEPROM, which port is upstream, and which port is switched off because of that choice.

It then steps through the start-up phases. If the mode asks for it, it first requests an EEPROM load and waits for the load engine to answer with a done pulse. Next comes an optional hold phase. In that phase the rest of the device stays in reset while management software can still reach the configuration space. The hold ends only when software writes zero to the halt bit of a control register. After that the block raises its ready flag and stays in the run state until the next reset.

A mode code that is reserved raises an error flag and parks the sequencer in its hold phase for good.

Top module: `boot_strap_seq`

## Requirements
- R1: While rst_n is low, every output is 0. The straps are sampled on the first rising clock edge with rst_n high. After that edge, later strap changes have no effect on any output.
- R2: Codes 0x0 and 0x1 give single partition: multi_part=0, upstream_port=0, port_disable=0. ee_init_en is 1 only for 0x1.
- R3: Codes 0x8 and 0xA give upstream_port=0 with port_disable bit 2 set. Codes 0x9 and 0xB give upstream_port=2 with port_disable bit 0 set. For all four, multi_part=0, and ee_init_en is 1 only for 0xA and 0xB.
- R4: Codes 0xC and 0xD give multi_part=1, upstream_port=0 and port_disable=0. ee_init_en is 1 only for 0xD.
- R5: Codes 0x2 to 0x7, 0xE and 0xF are reserved. For these, mode_reserved=1 and multi_part, ee_init_en, upstream_port and port_disable are all 0. halt_active stays 1 and boot_ready stays 0 until reset, even after the halt bit is cleared.
- R6: For EEPROM modes only, ee_load_req rises right after the sampling edge. It stays high until an edge that sees ee_load_done high, and is low after that edge. ee_load_done has no effect in any other phase.
- R7: Once the load phase is over, or right after sampling for modes without EEPROM, the block enters one of two states. If the halt bit is 1 it enters hold (halt_active=1). If the halt bit is 0 it enters run (boot_ready=1).
- R8: halt_bit is 0 in reset and takes the halt strap value at the sampling edge. A write with cfg_wr_en=1 and cfg_wr_addr equal to CTRL_ADDR (default 0x4) loads cfg_wr_halt into halt_bit at that edge. Writes to any other address leave it unchanged.
- R9: In hold with a non-reserved mode, the edge after halt_bit becomes 0 moves the block to run: boot_ready=1 and halt_active=0.
- R10: Once boot_ready is 1 it stays 1 until reset. Setting the halt bit again has no effect on it.
- R11: At most one of ee_load_req, halt_active and boot_ready is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous assert |
| mode_strap | input | 4 | Static boot mode code |
| halt_strap | input | 1 | Request to hold after reset |
| ee_load_req | output | 1 | EEPROM configuration load request |
| ee_load_done | input | 1 | Load complete pulse |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_addr | input | CFG_AW (4) | Control register write address |
| cfg_wr_halt | input | 1 | New value of the halt bit |
| halt_bit | output | 1 | Current halt bit |
| multi_part | output | 1 | Multi-partition operation selected |
| ee_init_en | output | 1 | EEPROM initialization selected |
| upstream_port | output | PORT_W (3) | Upstream port number |
| port_disable | output | NUM_PORTS (8) | One bit per port switched off by the mode |
| mode_reserved | output | 1 | Strap held a reserved code |
| halt_active | output | 1 | Sequencer is in the hold phase |
| boot_ready | output | 1 | Sequencer reached run |

## Verification
The bench uses the default build: eight ports, upstream choices 0 and 2, a 4-bit control address and control address 0x4. Every one of the sixteen strap codes can therefore be applied, and the full port_disable vector can be checked bit by bit. The bench steps through all codes with the halt strap both low and high, and adds seeded random runs with varied load latencies. This exercises the load handshake, writes to the wrong address while in hold, late strap toggling, re-setting the halt bit in run, and parking on reserved codes.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_LOAD   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_RUN    = 2'd3
    } boot_state_e;

    localparam logic [3:0] MODE_SINGLE     = 4'h0;
    localparam logic [3:0] MODE_SINGLE_EE  = 4'h1;
    localparam logic [3:0] MODE_UPA        = 4'h8;
    localparam logic [3:0] MODE_UPB        = 4'h9;
    localparam logic [3:0] MODE_UPA_EE     = 4'hA;
    localparam logic [3:0] MODE_UPB_EE     = 4'hB;
    localparam logic [3:0] MODE_MULTI      = 4'hC;
    localparam logic [3:0] MODE_MULTI_EE   = 4'hD;

    typedef struct packed {
        logic reserved;
        logic multi;
        logic ee;
        logic upsel;
        logic alt_up;
    } mode_info_t;

endpackage

// File: rtl/boot_mode_decode.sv
`timescale 1ns/1ps
module boot_mode_decode
    import boot_seq_pkg::*;
(
    input  logic [3:0]  mode,
    output mode_info_t  info
);
    always_comb begin
        info = '0;
        case (mode)
            MODE_SINGLE:    ;
            MODE_SINGLE_EE: info.ee = 1'b1;
            MODE_UPA:       info.upsel = 1'b1;
            MODE_UPB: begin
                info.upsel  = 1'b1;
                info.alt_up = 1'b1;
            end
            MODE_UPA_EE: begin
                info.upsel = 1'b1;
                info.ee    = 1'b1;
            end
            MODE_UPB_EE: begin
                info.upsel  = 1'b1;
                info.alt_up = 1'b1;
                info.ee     = 1'b1;
            end
            MODE_MULTI:     info.multi = 1'b1;
            MODE_MULTI_EE: begin
                info.multi = 1'b1;
                info.ee    = 1'b1;
            end
            default:        info.reserved = 1'b1;
        endcase
    end
endmodule

// File: rtl/boot_port_map.sv
`timescale 1ns/1ps
module boot_port_map #(
    parameter int NUM_PORTS  = 8,
    parameter int PRIMARY_UP = 0,
    parameter int ALT_UP     = 2,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 upsel,
    input  logic                 alt_up,
    output logic [PORT_W-1:0]    up_port,
    output logic [NUM_PORTS-1:0] dis_mask
);
    localparam logic [PORT_W-1:0] UP_A = PORT_W'(PRIMARY_UP);
    localparam logic [PORT_W-1:0] UP_B = PORT_W'(ALT_UP);

    assign up_port = (upsel && alt_up) ? UP_B : UP_A;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dis
        localparam bit IS_A = (p == PRIMARY_UP);
        localparam bit IS_B = (p == ALT_UP);
        // The upstream choice not taken switches its port off.
        assign dis_mask[p] = upsel && (alt_up ? IS_A : IS_B);
    end
endmodule

// File: rtl/boot_halt_reg.sv
`timescale 1ns/1ps
module boot_halt_reg #(
    parameter int              CFG_AW    = 4,
    parameter logic [CFG_AW-1:0] CTRL_ADDR = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              halt_strap,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic              wr_halt,
    output logic              halt_q_o
);
    typedef struct packed {
        logic halt;
    } halt_reg_t;

    halt_reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (sample) begin
            reg_d.halt = halt_strap;
        end else if (wr_en && (wr_addr == CTRL_ADDR)) begin
            reg_d.halt = wr_halt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign halt_q_o = reg_q.halt;
endmodule

// File: rtl/boot_seq_fsm.sv
`timescale 1ns/1ps
module boot_seq_fsm
    import boot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_strap,
    input  logic       halt_strap,
    input  logic       live_reserved,
    input  logic       live_ee,
    input  logic       kept_reserved,
    input  logic       halt_bit,
    input  logic       ee_done,
    output logic [3:0] mode_q_o,
    output logic       sample,
    output logic       ee_req,
    output logic       hold,
    output logic       ready
);
    typedef struct packed {
        boot_state_e state;
        logic [3:0]  mode;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_SAMPLE: begin
                fsm_d.mode = mode_strap;
                if (live_reserved) begin
                    fsm_d.state = ST_HOLD;
                end else if (live_ee) begin
                    fsm_d.state = ST_LOAD;
                end else if (halt_strap) begin
                    fsm_d.state = ST_HOLD;
                end else begin
                    fsm_d.state = ST_RUN;
                end
            end
            ST_LOAD: begin
                if (ee_done) begin
                    fsm_d.state = halt_bit ? ST_HOLD : ST_RUN;
                end
            end
            ST_HOLD: begin
                if (!kept_reserved && !halt_bit) begin
                    fsm_d.state = ST_RUN;
                end
            end
            ST_RUN: ;
            default: fsm_d.state = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_SAMPLE, mode: 4'h0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign mode_q_o = fsm_q.mode;
    assign sample   = (fsm_q.state == ST_SAMPLE);
    assign ee_req   = (fsm_q.state == ST_LOAD);
    assign hold     = (fsm_q.state == ST_HOLD);
    assign ready    = (fsm_q.state == ST_RUN);
endmodule

// File: rtl/boot_strap_seq.sv
`timescale 1ns/1ps
module boot_strap_seq
    import boot_seq_pkg::*;
#(
    parameter int                NUM_PORTS  = 8,
    parameter int                PRIMARY_UP = 0,
    parameter int                ALT_UP     = 2,
    parameter int                CFG_AW     = 4,
    parameter logic [CFG_AW-1:0] CTRL_ADDR  = 4'h4,
    localparam int               PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           mode_strap,
    input  logic                 halt_strap,
    output logic                 ee_load_req,
    input  logic                 ee_load_done,
    input  logic                 cfg_wr_en,
    input  logic [CFG_AW-1:0]    cfg_wr_addr,
    input  logic                 cfg_wr_halt,
    output logic                 halt_bit,
    output logic                 multi_part,
    output logic                 ee_init_en,
    output logic [PORT_W-1:0]    upstream_port,
    output logic [NUM_PORTS-1:0] port_disable,
    output logic                 mode_reserved,
    output logic                 halt_active,
    output logic                 boot_ready
);
    mode_info_t live_info;
    mode_info_t kept_info;
    logic [3:0] mode_q;
    logic       sample;

    boot_mode_decode u_live_dec (
        .mode (mode_strap),
        .info (live_info)
    );

    boot_mode_decode u_kept_dec (
        .mode (mode_q),
        .info (kept_info)
    );

    boot_port_map #(
        .NUM_PORTS  (NUM_PORTS),
        .PRIMARY_UP (PRIMARY_UP),
        .ALT_UP     (ALT_UP)
    ) u_map (
        .upsel    (kept_info.upsel),
        .alt_up   (kept_info.alt_up),
        .up_port  (upstream_port),
        .dis_mask (port_disable)
    );

    boot_halt_reg #(
        .CFG_AW    (CFG_AW),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_halt (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (sample),
        .halt_strap (halt_strap),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_halt    (cfg_wr_halt),
        .halt_q_o   (halt_bit)
    );

    boot_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_strap    (mode_strap),
        .halt_strap    (halt_strap),
        .live_reserved (live_info.reserved),
        .live_ee       (live_info.ee),
        .kept_reserved (kept_info.reserved),
        .halt_bit      (halt_bit),
        .ee_done       (ee_load_done),
        .mode_q_o      (mode_q),
        .sample        (sample),
        .ee_req        (ee_load_req),
        .hold          (halt_active),
        .ready         (boot_ready)
    );

    assign multi_part    = kept_info.multi;
    assign ee_init_en    = kept_info.ee;
    assign mode_reserved = kept_info.reserved;
endmodule

// File: rtl/boot_strap_seq_chk.sv
`timescale 1ns/1ps
module boot_strap_seq_chk #(
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ee_load_req,
    input logic                 ee_load_done,
    input logic                 halt_bit,
    input logic                 multi_part,
    input logic                 ee_init_en,
    input logic [PORT_W-1:0]    upstream_port,
    input logic [NUM_PORTS-1:0] port_disable,
    input logic                 mode_reserved,
    input logic                 halt_active,
    input logic                 boot_ready
);
    a_r11_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ee_load_req, halt_active, boot_ready}) <= 1);

    a_r6_req_needs_ee: assert property (@(posedge clk) disable iff (!rst_n)
        ee_load_req |-> ee_init_en);

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_load_req && !ee_load_done) |=> ee_load_req);

    a_r6_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_load_req && ee_load_done) |=> !ee_load_req);

    a_r5_reserved_parks: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reserved |-> (!boot_ready && !ee_load_req));

    a_r10_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        boot_ready |=> boot_ready);

    a_r1_fields_static: assert property (@(posedge clk) disable iff (!rst_n)
        boot_ready |=> $stable({multi_part, ee_init_en, upstream_port, port_disable, mode_reserved}));

    a_r3_single_disable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_disable));

    a_r4_multi_no_disable: assert property (@(posedge clk) disable iff (!rst_n)
        multi_part |-> (port_disable == '0));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_active && !halt_bit && !mode_reserved) |=> boot_ready);
endmodule

bind boot_strap_seq boot_strap_seq_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ee_load_req   (ee_load_req),
    .ee_load_done  (ee_load_done),
    .halt_bit      (halt_bit),
    .multi_part    (multi_part),
    .ee_init_en    (ee_init_en),
    .upstream_port (upstream_port),
    .port_disable  (port_disable),
    .mode_reserved (mode_reserved),
    .halt_active   (halt_active),
    .boot_ready    (boot_ready)
);

// File: tb/tb_boot_strap_seq.sv
`timescale 1ns/1ps
module tb_boot_strap_seq;
    localparam logic [3:0] CTRL_ADDR = 4'h4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_strap = 4'h0;
    logic       halt_strap = 1'b0;
    logic       ee_load_req;
    logic       ee_load_done = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [3:0] cfg_wr_addr = 4'h0;
    logic       cfg_wr_halt = 1'b0;
    logic       halt_bit;
    logic       multi_part;
    logic       ee_init_en;
    logic [2:0] upstream_port;
    logic [7:0] port_disable;
    logic       mode_reserved;
    logic       halt_active;
    logic       boot_ready;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    boot_strap_seq dut (.*);

    typedef struct packed {
        logic       rsv;
        logic       multi;
        logic       ee;
        logic [2:0] up;
        logic [7:0] mask;
    } exp_t;

    function automatic exp_t expect_fields(input logic [3:0] m);
        exp_t e = '0;
        case (m)
            4'h0: ;
            4'h1: e.ee = 1'b1;
            4'h8: e.mask = 8'h04;
            4'h9: begin e.up = 3'd2; e.mask = 8'h01; end
            4'hA: begin e.ee = 1'b1; e.mask = 8'h04; end
            4'hB: begin e.ee = 1'b1; e.up = 3'd2; e.mask = 8'h01; end
            4'hC: e.multi = 1'b1;
            4'hD: begin e.multi = 1'b1; e.ee = 1'b1; end
            default: e.rsv = 1'b1;
        endcase
        return e;
    endfunction

    function automatic string field_req(input logic [3:0] m);
        if (m == 4'h0 || m == 4'h1) return "R2";
        if (m >= 4'h8 && m <= 4'hB) return "R3";
        if (m == 4'hC || m == 4'hD) return "R4";
        return "R5";
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [3:0] addr, input logic v);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = addr;
        cfg_wr_halt = v;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    function automatic logic [31:0] fields_now();
        return {17'd0, mode_reserved, multi_part, ee_init_en, upstream_port, port_disable};
    endfunction

    task automatic boot_run(input logic [3:0] m, input logic h, input int load_wait);
        exp_t e;
        e = expect_fields(m);
        rst_n = 1'b0;
        mode_strap = m;
        halt_strap = h;
        cfg_wr_en = 1'b0;
        ee_load_done = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check({fields_now()[13:0], boot_ready, halt_active, ee_load_req, halt_bit}, 32'd0,
              "R1", "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: strap toggling after the sampling edge must be ignored
        mode_strap = ~m;
        halt_strap = ~h;
        check(fields_now(), {17'd0, e}, field_req(m), "decoded fields");
        check(halt_bit, h, "R8", "halt bit loaded from strap");
        if (e.rsv) begin
            check(halt_active, 1'b1, "R5", "reserved parks in hold");
            write_ctrl(CTRL_ADDR, 1'b0);
            repeat (3) @(negedge clk);
            check({boot_ready, halt_active}, 2'b01, "R5", "reserved stays held after clear");
        end else begin
            if (e.ee) begin
                check(ee_load_req, 1'b1, "R6", "load request raised");
                for (int i = 0; i < load_wait; i++) @(negedge clk);
                check({ee_load_req, boot_ready}, 2'b10, "R6", "request held until done");
                ee_load_done = 1'b1;
                @(negedge clk);
                ee_load_done = 1'b0;
                check(ee_load_req, 1'b0, "R6", "request dropped after done");
            end else begin
                check(ee_load_req, 1'b0, "R6", "no request without EEPROM mode");
                ee_load_done = 1'b1;
                @(negedge clk);
                ee_load_done = 1'b0;
                check(ee_load_req, 1'b0, "R6", "stray done ignored");
            end
            if (h) begin
                check({halt_active, boot_ready}, 2'b10, "R7", "hold entered");
                write_ctrl(CTRL_ADDR ^ 4'h1, 1'b0);
                @(negedge clk);
                check({halt_bit, halt_active}, 2'b11, "R8", "write to other address ignored");
                write_ctrl(CTRL_ADDR, 1'b0);
                check({halt_bit, halt_active}, 2'b01, "R8", "halt bit cleared by write");
                @(negedge clk);
                check({boot_ready, halt_active}, 2'b10, "R9", "release to run");
            end else begin
                check({boot_ready, halt_active}, 2'b10, "R7", "run entered directly");
            end
            write_ctrl(CTRL_ADDR, 1'b1);
            check(halt_bit, 1'b1, "R8", "halt bit set in run");
            @(negedge clk);
            check(boot_ready, 1'b1, "R10", "ready stays after halt bit set");
        end
        check({boot_ready, halt_active, ee_load_req} == 3'b000 ? 32'd0 :
              32'($countones({boot_ready, halt_active, ee_load_req})), 32'd1,
              "R11", "single active phase");
        check(fields_now(), {17'd0, e}, "R1", "fields unchanged by late straps");
    endtask

    initial begin
        void'($urandom(32'h5EED_0B07));
        for (int m = 0; m < 16; m++) begin
            for (int h = 0; h < 2; h++) begin
                boot_run(4'(m), 1'(h), (m + h) % 4);
            end
        end
        for (int n = 0; n < 40; n++) begin
            boot_run(4'($urandom % 16), 1'($urandom % 2), int'($urandom % 6));
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule